// File: doc/BRIEF.md
# Powerdown and Calibration Sequencer

This block runs the slow control side of one clock-recovery channel. A single active-high pin drives it. While the pin is high, the channel is powered down: the output drivers are turned off and the recovery core is held in reset. When the pin drops, the sequencer looks at how long the pin was high. After a long enough pulse it resets its own control state, waits for a usable reference clock and asks an external calibration engine to run. When calibration reports done, it releases the recovery core and follows lock acquisition until the core reports lock.

After a short pulse there is no calibration. The core goes straight back to lock acquisition. An acquisition that takes too long starts a fresh calibration. The loss-of-lock flag is kept quiet while powered down. Outside powerdown, the flag is forced high when the reference is invalid.

Top module: `pdcal_seq`

## Requirements
- R1: By the third rising clock edge after `pd_cal_pin` goes high, `drv_en` and `core_rst_n` are both 0 and `state_o` reads 0 (powered down). They stay that way while the pin stays high.
- R2: On reset, `state_o` is 1 (reset state), `cal_req` is 0, `core_rst_n` is 0 and `drv_en` is 1. The state codes are: 0 powered down, 1 reset, 2 calibrating, 3 acquiring, 4 running.
- R3: A release after the pin was high for at least `MIN_HIGH_CYC` clock cycles puts the sequencer in state 1 on the third edge after the release. With the reference valid, it moves to state 2 with `cal_req` high on the next edge.
- R4: A release after fewer than `MIN_HIGH_CYC` high cycles never raises `cal_req`. The sequencer enters state 3 on the third edge after the release.
- R5: In state 1 with `ref_valid` low, the sequencer stays in state 1 with `cal_req` low. It moves to state 2 on the first edge that sees `ref_valid` high.
- R6: In state 2, `cal_req` is high and `core_rst_n` is low until `cal_done` is seen. The next edge then enters state 3 with `core_rst_n` high.
- R7: State 3 moves to state 4 on an edge where `lock_det` is high. State 4 returns to state 3 on an edge where `lock_det` is low.
- R8: If `lock_det` stays low, state 3 lasts exactly `ACQ_TMO_CYC` cycles and then returns to state 1 to recalibrate.
- R9: `lol_out` is 0 in state 0. In every other state it equals `lol_raw` OR NOT `ref_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_cal_pin | input | 1 | Asynchronous powerdown/calibrate pin, active high |
| ref_valid | input | 1 | Reference clock is present and usable |
| cal_done | input | 1 | Calibration engine has finished |
| lock_det | input | 1 | Recovery core reports frequency lock |
| lol_raw | input | 1 | Unmasked loss-of-lock from the lock detector |
| drv_en | output | 1 | Enable for the data and clock output drivers |
| core_rst_n | output | 1 | Active-low reset to the recovery core |
| cal_req | output | 1 | Request to the calibration engine |
| lol_out | output | 1 | Masked loss-of-lock flag |
| state_o | output | 3 | Sequencer state code |

## Verification
The assertions assume the synchronized pin is a clean level. They also assume `cal_done` and `lock_det` are only meaningful in the states that read them, and that the reference flag changes only between clock edges. The stimulus drives every input at the falling clock edge, so each value is stable for a full cycle. It sweeps the high-pulse length from one cycle up to a few cycles past the threshold. Each release waits out the synchronizer latency before the next pulse starts, so no two pin edges ever overlap inside the synchronizer. The timeout and reference-wait cases are run with a short timeout so every window finishes well within the run.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

  typedef enum logic [2:0] {
    ST_PDOWN = 3'd0,
    ST_RESET = 3'd1,
    ST_CAL   = 3'd2,
    ST_ACQ   = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_e;

  // saturating increment toward a ceiling
  function automatic int unsigned sat_step(int unsigned v, int unsigned ceil);
    return (v >= ceil) ? ceil : v + 1;
  endfunction

  // a high pulse qualifies once its cycle count reaches the threshold
  function automatic logic pulse_is_long(int unsigned cnt, int unsigned thr);
    return cnt >= thr;
  endfunction

  // the timer expires on the last cycle of its window
  function automatic logic window_end(int unsigned cnt, int unsigned len);
    return cnt == len - 1;
  endfunction

endpackage

// File: rtl/pdcal_sync.sv
module pdcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pdcal_hold.sv
module pdcal_hold
  import pdcal_pkg::*;
#(
  parameter int MIN_HIGH_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall_evt,
  output logic fall_long
);
  localparam int CW = $clog2(MIN_HIGH_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lvl_d_q <= 1'b0;
    end else begin
      lvl_d_q <= lvl;
      if (lvl) cnt_q <= CW'(sat_step(32'(cnt_q), MIN_HIGH_CYC));
      else     cnt_q <= '0;
    end
  end

  assign fall_evt  = lvl_d_q & ~lvl;
  assign fall_long = fall_evt & pulse_is_long(32'(cnt_q), MIN_HIGH_CYC);
endmodule

// File: rtl/pdcal_timer.sv
module pdcal_timer
  import pdcal_pkg::*;
#(
  parameter int LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign expired = run & window_end(32'(cnt_q), LIMIT);
endmodule

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
  import pdcal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_lvl,
  input  logic       fall_evt,
  input  logic       fall_long,
  input  logic       ref_valid,
  input  logic       cal_done,
  input  logic       lock_det,
  input  logic       acq_tmo,
  output seq_state_e state_q
);
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (pin_lvl) begin
      state_d = ST_PDOWN;
    end else begin
      unique case (state_q)
        ST_PDOWN: if (fall_long)     state_d = ST_RESET;
                  else if (fall_evt) state_d = ST_ACQ;
        ST_RESET: if (ref_valid)     state_d = ST_CAL;
        ST_CAL:   if (cal_done)      state_d = ST_ACQ;
        ST_ACQ:   if (lock_det)      state_d = ST_RUN;
                  else if (acq_tmo)  state_d = ST_RESET;
        ST_RUN:   if (!lock_det)     state_d = ST_ACQ;
        default:                     state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq
  import pdcal_pkg::*;
#(
  parameter int MIN_HIGH_CYC = 100,
  parameter int ACQ_TMO_CYC  = 200000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_cal_pin,
  input  logic       ref_valid,
  input  logic       cal_done,
  input  logic       lock_det,
  input  logic       lol_raw,
  output logic       drv_en,
  output logic       core_rst_n,
  output logic       cal_req,
  output logic       lol_out,
  output logic [2:0] state_o
);
  logic       pin_lvl;
  logic       fall_evt;
  logic       fall_long;
  logic       acq_tmo;
  logic       in_acq;
  seq_state_e state_q;

  pdcal_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pd_cal_pin),
    .q_sync (pin_lvl)
  );

  pdcal_hold #(.MIN_HIGH_CYC(MIN_HIGH_CYC)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (pin_lvl),
    .fall_evt (fall_evt),
    .fall_long(fall_long)
  );

  assign in_acq = (state_q == ST_ACQ);

  pdcal_timer #(.LIMIT(ACQ_TMO_CYC)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_acq),
    .expired(acq_tmo)
  );

  pdcal_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .fall_evt (fall_evt),
    .fall_long(fall_long),
    .ref_valid(ref_valid),
    .cal_done (cal_done),
    .lock_det (lock_det),
    .acq_tmo  (acq_tmo),
    .state_q  (state_q)
  );

  assign drv_en     = (state_q != ST_PDOWN);
  assign core_rst_n = (state_q == ST_ACQ) || (state_q == ST_RUN);
  assign cal_req    = (state_q == ST_CAL);
  assign lol_out    = (state_q != ST_PDOWN) && (lol_raw || !ref_valid);
  assign state_o    = state_q;
endmodule

// File: rtl/pdcal_seq_chk.sv
module pdcal_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_lvl,
  input logic       fall_evt,
  input logic       fall_long,
  input logic       acq_tmo,
  input logic       ref_valid,
  input logic       lock_det,
  input logic       cal_req,
  input logic       drv_en,
  input logic       core_rst_n,
  input logic       lol_out,
  input logic [2:0] state_o
);
  logic is_run;
  assign is_run = (state_o == 3'd4);

  AST_PD_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lvl |=> (!drv_en && !core_rst_n)); // R1
  AST_PD_LOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lvl |=> !lol_out); // R9
  AST_LONG_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    fall_long |=> (state_o == 3'd1)); // R3
  AST_SHORT_NO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !fall_long) |=> (state_o == 3'd3 && !cal_req)); // R4
  AST_CAL_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req) |-> $past(ref_valid)); // R5
  AST_CAL_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> !core_rst_n); // R6
  AST_RUN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_run) |-> $past(lock_det)); // R7
  AST_TMO_RECAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_tmo && !pin_lvl && !lock_det) |=> (state_o == 3'd1)); // R8
endmodule

bind pdcal_seq pdcal_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_lvl   (pin_lvl),
  .fall_evt  (fall_evt),
  .fall_long (fall_long),
  .acq_tmo   (acq_tmo),
  .ref_valid (ref_valid),
  .lock_det  (lock_det),
  .cal_req   (cal_req),
  .drv_en    (drv_en),
  .core_rst_n(core_rst_n),
  .lol_out   (lol_out),
  .state_o   (state_o)
);

// File: tb/test_pdcal_seq.sv
module test_pdcal_seq;
  localparam int MINH = 8;
  localparam int TMO  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_cal_pin = 1'b0;
  logic       ref_valid = 1'b1;
  logic       cal_done = 1'b0;
  logic       lock_det = 1'b0;
  logic       lol_raw = 1'b0;
  logic       drv_en, core_rst_n, cal_req, lol_out;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  pdcal_seq #(.MIN_HIGH_CYC(MINH), .ACQ_TMO_CYC(TMO)) i_pdcal_seq (
    .clk(clk), .rst_n(rst_n), .pd_cal_pin(pd_cal_pin), .ref_valid(ref_valid),
    .cal_done(cal_done), .lock_det(lock_det), .lol_raw(lol_raw),
    .drv_en(drv_en), .core_rst_n(core_rst_n), .cal_req(cal_req),
    .lol_out(lol_out), .state_o(state_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset state
    chk("R2 state", int'(state_o), 1);
    chk("R2 cal_req", int'(cal_req), 0);
    chk("R2 core_rst_n", int'(core_rst_n), 0);
    chk("R2 drv_en", int'(drv_en), 1);
    @(negedge clk);
    chk("R5 ref ok -> cal", int'(state_o), 2);
    chk("R6 cal_req", int'(cal_req), 1);
    chk("R6 core held", int'(core_rst_n), 0);
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    chk("R6 done -> acq", int'(state_o), 3);
    chk("R6 core released", int'(core_rst_n), 1);
    lock_det = 1'b1;
    @(negedge clk);
    chk("R7 lock -> run", int'(state_o), 4);
    // R9 lol masking outside powerdown
    lol_raw = 1'b1; #1;
    chk("R9 lol raw", int'(lol_out), 1);
    lol_raw = 1'b0; ref_valid = 1'b0; #1;
    chk("R9 ref lost", int'(lol_out), 1);
    ref_valid = 1'b1; #1;
    chk("R9 clear", int'(lol_out), 0);

    // sweep pulse lengths across the threshold (R1, R3, R4, R9)
    lock_det = 1'b0;
    @(negedge clk);
    for (int h = 1; h <= MINH + 3; h++) begin
      bit long_p;
      bit saw_req;
      long_p = (h >= MINH);
      saw_req = 1'b0;
      pd_cal_pin = 1'b1;
      lol_raw = 1'b1;
      for (int k = 1; k <= h; k++) begin
        @(negedge clk);
        if (k == 3) begin
          chk("R1 pd state", int'(state_o), 0);
          chk("R1 drv off", int'(drv_en), 0);
          chk("R1 core reset", int'(core_rst_n), 0);
          chk("R9 lol quiet", int'(lol_out), 0);
        end
      end
      pd_cal_pin = 1'b0;
      lol_raw = 1'b0;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (cal_req) saw_req = 1'b1;
        if (k == 3)
          chk(long_p ? "R3 release -> reset" : "R4 release -> acq",
              int'(state_o), long_p ? 1 : 3);
      end
      if (long_p) begin
        chk("R3 cal state", int'(state_o), 2);
        chk("R3 cal_req", int'(cal_req), 1);
      end else begin
        chk("R4 no cal_req", int'(saw_req), 0);
        chk("R4 acq state", int'(state_o), 3);
      end
    end

    // R5 reference invalid at release
    ref_valid = 1'b0;
    pd_cal_pin = 1'b1;
    repeat (10) @(negedge clk);
    pd_cal_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 wait state", int'(state_o), 1);
    chk("R5 no cal_req", int'(cal_req), 0);
    ref_valid = 1'b1;
    @(negedge clk);
    chk("R5 ref back -> cal", int'(state_o), 2);

    // R8 acquisition timeout
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    ref_valid = 1'b0;
    chk("R8 acq entered", int'(state_o), 3);
    repeat (TMO - 1) @(negedge clk);
    chk("R8 still acq", int'(state_o), 3);
    @(negedge clk);
    chk("R8 timeout -> reset", int'(state_o), 1);

    // R7 lock loss returns to acquisition
    ref_valid = 1'b1;
    @(negedge clk);
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    lock_det = 1'b1;
    @(negedge clk);
    chk("R7 run", int'(state_o), 4);
    lock_det = 1'b0;
    @(negedge clk);
    chk("R7 lock lost -> acq", int'(state_o), 3);

    finish_run();
  end
endmodule